// File: doc/BRIEF.md
# Grouped interrupt controller

This block gathers twenty-four interrupt request lines, organised as three groups of eight, and folds them into one active-high request to the processor. Each line is brought into the clock domain, then qualified per bit as either an edge or a level of a chosen sense. A qualifying event sets a sticky pending bit, and any pending bit that is not masked drives the processor request.

Software reaches the per-group registers through a small byte-wide register port. Each group has four registers: pending, sense, trigger-mode and mask. An offset is formed as `kind * 4 + group`, so each kind of register occupies a four-byte row. A handler reads the pending bytes and acknowledges sources by writing ones back. Sources stay masked until software unmasks them.

Top module: `grp_irq_ctrl`

## Requirements
- R1: Source `n` of group `g` is input bit `g*8+n` and bit `n` of that group's registers. The 4-bit register offset is `kind*4 + g`, with kind 0 = pending, 1 = sense, 2 = trigger-mode and 3 = mask. Offsets with group field 3 (0x3, 0x7, 0xB, 0xF) read as zero and writes to them change nothing.
- R2: After reset, mask and trigger-mode bytes read 0xFF, sense and pending bytes read 0x00, and `irq_out` is 0.
- R3: Writing 1 to a pending bit clears it, writing 0 leaves it unchanged, and a read returns the latched pending byte.
- R4: A mask bit of 1 keeps its source from driving `irq_out`, while the pending bit still latches. A mask bit of 0 lets it through.
- R5: A trigger-mode bit of 1 selects edge detection and 0 selects level detection. A sense bit of 0 selects a rising edge or high level, and 1 selects a falling edge or low level. The opposite transition does not set pending.
- R6: When an input changes just after a clock edge, its pending bit is readable after the third following rising edge, through two synchroniser flops and the pending register. `irq_out` follows one edge later.
- R7: In level mode, a pending bit cleared while its active level is still present is set again at once.
- R8: When a detected event and a write-one-to-clear meet the same bit in the same cycle, the bit stays set.
- R9: `irq_out` is a register holding the OR over all groups of pending AND NOT mask. Unmasking a source with a stale pending bit therefore raises `irq_out` one edge after the mask write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 24 | Raw request lines, group-major |
| reg_addr | input | 4 | Register offset |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Registered processor request, active high |

## Verification
Detection of a new event and a software acknowledge can strike the same pending bit in the same cycle. The bench provokes this in two ways. In level mode it writes a clear while the line is held active. In edge mode it times the clear so that it is sampled on the exact edge where the detected transition reaches the pending register. In both cases the bench judges by reading the pending byte back and expects the bit to remain set. It then shows that a later clear, with no event present, does take effect.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;

  localparam int KIND_W = 2;
  localparam int GSEL_W = 2;
  localparam int OFFS_W = KIND_W + GSEL_W;

  typedef enum logic [KIND_W-1:0] {
    KIND_PEND  = 2'd0,
    KIND_SENSE = 2'd1,
    KIND_TRIG  = 2'd2,
    KIND_MASK  = 2'd3
  } reg_kind_e;

  // Register offset: kind selects a row of four, group selects the column.
  function automatic logic [OFFS_W-1:0] reg_offset(reg_kind_e kind, int grp);
    return {kind, GSEL_W'(grp)};
  endfunction

  // One source's qualifying event from its synchronised value and the value
  // one clock earlier. sense_low inverts the active sense; trig_edge picks
  // edge detection over level detection.
  function automatic logic src_event(logic cur, logic prev, logic sense_low, logic trig_edge);
    logic act_now;
    logic act_prev;
    act_now  = cur ^ sense_low;
    act_prev = prev ^ sense_low;
    return trig_edge ? (act_now & ~act_prev) : act_now;
  endfunction

  // Sticky pending update: a fresh event outranks a clear in the same cycle.
  function automatic logic pend_next(logic held, logic evt, logic clr);
    return evt | (held & ~clr);
  endfunction

endpackage

// File: rtl/grp_irq_sync.sv
module grp_irq_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  logic [W-1:0] meta_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;

endmodule

// File: rtl/grp_irq_group.sv
module grp_irq_group #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] cur,
  input  logic [GW-1:0] prev,
  input  logic [GW-1:0] sense,
  input  logic [GW-1:0] trig,
  input  logic [GW-1:0] clr,
  output logic [GW-1:0] pend,
  output logic [GW-1:0] evt
);
  import grp_irq_pkg::*;

  logic [GW-1:0] evt_w;
  logic [GW-1:0] pend_q;

  for (genvar b = 0; b < GW; b++) begin : g_bit
    assign evt_w[b] = src_event(cur[b], prev[b], sense[b], trig[b]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[b] <= 1'b0;
      else        pend_q[b] <= pend_next(pend_q[b], evt_w[b], clr[b]);
    end
  end

  assign pend = pend_q;
  assign evt  = evt_w;

  AST_PEND_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(evt_w)) == '0)); // R5

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_w) & $past(clr) & ~pend_q) == '0)); // R8

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr) & ~$past(evt_w) & pend_q) == '0)); // R3

endmodule

// File: rtl/grp_irq_regs.sv
module grp_irq_regs #(
  parameter int NUM_GROUPS = 3,
  parameter int GW         = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [grp_irq_pkg::OFFS_W-1:0]       addr,
  input  logic                                 we,
  input  logic [GW-1:0]                        wdata,
  input  logic [NUM_GROUPS-1:0][GW-1:0]        pend_in,
  output logic [GW-1:0]                        rdata,
  output logic [NUM_GROUPS-1:0][GW-1:0]        sense,
  output logic [NUM_GROUPS-1:0][GW-1:0]        trig,
  output logic [NUM_GROUPS-1:0][GW-1:0]        mask,
  output logic [NUM_GROUPS-1:0][GW-1:0]        clr
);
  import grp_irq_pkg::*;

  logic [NUM_GROUPS-1:0][GW-1:0] sense_q;
  logic [NUM_GROUPS-1:0][GW-1:0] trig_q;
  logic [NUM_GROUPS-1:0][GW-1:0] mask_q;
  logic                          pend_wr_w;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sense_q[g] <= '0;
        trig_q[g]  <= '1;
        mask_q[g]  <= '1;
      end else if (we) begin
        if (addr == reg_offset(KIND_SENSE, g)) sense_q[g] <= wdata;
        if (addr == reg_offset(KIND_TRIG, g))  trig_q[g]  <= wdata;
        if (addr == reg_offset(KIND_MASK, g))  mask_q[g]  <= wdata;
      end
    end

    assign clr[g] = (we && addr == reg_offset(KIND_PEND, g)) ? wdata : '0;
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (addr == reg_offset(KIND_PEND, g))  rdata = pend_in[g];
      if (addr == reg_offset(KIND_SENSE, g)) rdata = sense_q[g];
      if (addr == reg_offset(KIND_TRIG, g))  rdata = trig_q[g];
      if (addr == reg_offset(KIND_MASK, g))  rdata = mask_q[g];
    end
  end

  assign pend_wr_w = we && (addr[OFFS_W-1:GSEL_W] == KIND_PEND);

  assign sense = sense_q;
  assign trig  = trig_q;
  assign mask  = mask_q;

  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr[GSEL_W-1:0]) >= NUM_GROUPS) |-> (rdata == '0)); // R1

  AST_ACK_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pend_wr_w) |-> $stable(mask_q)); // R1

endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl #(
  parameter  int NUM_GROUPS = 3,
  parameter  int GROUP_W    = 8,
  localparam int NSRC       = NUM_GROUPS * GROUP_W,
  localparam int ADDR_W     = grp_irq_pkg::OFFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    irq_in,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [GROUP_W-1:0] reg_wdata,
  output logic [GROUP_W-1:0] reg_rdata,
  output logic               irq_out
);

  logic [NSRC-1:0]                    cur_w;
  logic [NSRC-1:0]                    prev_w;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] pend_w;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] evt_w;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] sense_w;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] trig_w;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] mask_w;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] clr_w;
  logic                               live_w;
  logic                               irq_q;

  grp_irq_sync #(.W(NSRC)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (irq_in),
    .cur  (cur_w),
    .prev (prev_w)
  );

  grp_irq_regs #(.NUM_GROUPS(NUM_GROUPS), .GW(GROUP_W)) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (reg_addr),
    .we     (reg_we),
    .wdata  (reg_wdata),
    .pend_in(pend_w),
    .rdata  (reg_rdata),
    .sense  (sense_w),
    .trig   (trig_w),
    .mask   (mask_w),
    .clr    (clr_w)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    grp_irq_group #(.GW(GROUP_W)) group_i (
      .clk  (clk),
      .rst_n(rst_n),
      .cur  (cur_w[g*GROUP_W +: GROUP_W]),
      .prev (prev_w[g*GROUP_W +: GROUP_W]),
      .sense(sense_w[g]),
      .trig (trig_w[g]),
      .clr  (clr_w[g]),
      .pend (pend_w[g]),
      .evt  (evt_w[g])
    );
  end

  assign live_w = |(pend_w & ~mask_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= live_w;
  end

  assign irq_out = irq_q;

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_w) == '1) |-> !irq_out); // R4

  AST_STALE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|(pend_w & ~mask_w)) |-> irq_out); // R9

  AST_NO_EVENT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_w) == '0) |-> !irq_out); // R2

endmodule

// File: tb/grp_irq_ctrl_tb_top.sv
module grp_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NG   = 3;
  localparam int GW   = 8;
  localparam int NSRC = NG * GW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_in = '0;
  logic [3:0]      reg_addr = '0;
  logic            reg_we = 1'b0;
  logic [7:0]      reg_wdata = '0;
  logic [7:0]      reg_rdata;
  logic            irq_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_irq_ctrl dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq_out  (irq_out)
  );

  function automatic logic [3:0] off(int kind, int g);
    return 4'(kind * 4 + g);
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_raw(logic [3:0] a, logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic wr(int kind, int g, logic [7:0] d);
    wr_raw(off(kind, g), d);
  endtask

  task automatic rd_raw(logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd(int kind, int g, output logic [7:0] d);
    rd_raw(off(kind, g), d);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] exp;
    logic [7:0] bitv;
    logic       tg;
    logic       sn;
    int         g;

    ticks(2);
    rst_n = 1'b1;
    ticks(1);

    // R2 reset values, R1 unused offsets read zero
    for (int k = 0; k < 4; k++) begin
      for (int h = 0; h < 4; h++) begin
        rd(k, h, d);
        exp = (h == 3) ? 8'h00 : ((k >= 2) ? 8'hFF : 8'h00);
        check8("R2 reset register value", d, exp);
      end
    end
    check8("R2 reset irq_out", {7'd0, irq_out}, 8'h00);

    // R1 writes to unused offsets are ignored
    for (int k = 0; k < 4; k++) wr_raw(off(k, 3), 8'h5A);
    for (int k = 0; k < 4; k++) begin
      rd_raw(off(k, 3), d);
      check8("R1 unused offset reads zero", d, 8'h00);
    end
    for (int h = 0; h < NG; h++) begin
      rd(1, h, d); check8("R1 sense untouched by unused write", d, 8'h00);
      rd(2, h, d); check8("R1 trig untouched by unused write", d, 8'hFF);
      rd(3, h, d); check8("R1 mask untouched by unused write", d, 8'hFF);
    end

    // Sweep every source in every trigger/sense mode
    for (int m = 0; m < 4; m++) begin
      tg = m[1];
      sn = m[0];
      for (int i = 0; i < NSRC; i++) begin
        g    = i / GW;
        bitv = 8'(1) << (i % GW);
        irq_in = {NSRC{sn}};
        for (int h = 0; h < NG; h++) begin
          wr(1, h, {8{sn}});
          wr(2, h, {8{tg}});
          wr(3, h, 8'hFF);
        end
        ticks(4);
        for (int h = 0; h < NG; h++) wr(0, h, 8'hFF);
        for (int h = 0; h < NG; h++) begin
          rd(0, h, d);
          check8("R3 pending cleared by ones", d, 8'h00);
        end

        irq_in[i] = ~sn;
        ticks(2);
        rd(0, g, d);
        check8("R6 pending not yet visible after two edges", d, 8'h00);
        ticks(1);
        for (int h = 0; h < NG; h++) begin
          rd(0, h, d);
          check8("R5 R1 pending set for active source only", d, (h == g) ? bitv : 8'h00);
        end
        ticks(1);
        check8("R4 masked pending keeps irq low", {7'd0, irq_out}, 8'h00);

        wr(3, g, ~bitv);
        check8("R6 irq register lags mask write", {7'd0, irq_out}, 8'h00);
        ticks(1);
        check8("R9 stale pending raises irq on unmask", {7'd0, irq_out}, 8'h01);

        wr(0, g, 8'h00);
        rd(0, g, d);
        check8("R3 zero write keeps pending", d, bitv);

        wr(0, g, bitv);
        rd(0, g, d);
        if (!tg) begin
          check8("R7 R8 level still active re-sets pending", d, bitv);
          ticks(1);
          check8("R7 irq stays high in level mode", {7'd0, irq_out}, 8'h01);
        end else begin
          check8("R3 edge pending cleared", d, 8'h00);
          ticks(1);
          check8("R9 irq drops after clear", {7'd0, irq_out}, 8'h00);
        end

        irq_in[i] = sn;
        ticks(3);
        rd(0, g, d);
        if (!tg) begin
          check8("R3 level pending held after release", d, bitv);
          wr(0, g, bitv);
          rd(0, g, d);
          check8("R7 level pending clears once inactive", d, 8'h00);
        end else begin
          check8("R5 opposite edge does not set pending", d, 8'h00);
        end
        ticks(1);
        check8("R9 irq low with nothing pending", {7'd0, irq_out}, 8'h00);
        wr(3, g, 8'hFF);
      end
    end

    // R8 edge mode: clear sampled on the same edge as the detected event
    irq_in = '0;
    for (int h = 0; h < NG; h++) begin
      wr(1, h, 8'h00);
      wr(2, h, 8'hFF);
      wr(3, h, 8'hFF);
    end
    ticks(4);
    for (int h = 0; h < NG; h++) wr(0, h, 8'hFF);
    irq_in[5] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_addr  = off(0, 0);
    reg_wdata = 8'h20;
    reg_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we    = 1'b0;
    rd(0, 0, d);
    check8("R8 edge event beats same-cycle clear", d, 8'h20);
    wr(0, 0, 8'h20);
    rd(0, 0, d);
    check8("R8 later clear takes effect", d, 8'h00);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule